// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block takes a write-only serial programming bus made of a bit clock, a data line and an active-low frame enable. It samples all three lines with the system clock. While the frame enable is low, each rising edge of the bit clock shifts one data bit into a 24-bit shift register, most significant bit first. When the frame enable returns high, the last bit received selects the destination. If it is 1, the 23 bits above it become the long channel word. If it is 0, only the 11 bits just above it become the short setup word.

Both words drive decoded field outputs: divider codes, oscillator band select, filter and compensation enables, trim codes, charge-pump trim and test selection. The port never counts bits. Surplus leading bits fall off the top of the register. A short frame is completed by whatever bits the register already held.

A controller with three states runs the sequence. ST_IDLE covers frame enable high. The transition IDLE_TO_SHIFT is taken when the synchronised enable is low. ST_SHIFT accepts bit-clock rising edges. The transition SHIFT_TO_LOAD is taken when the synchronised enable is high again. ST_LOAD lasts one cycle and commits the word. The transition LOAD_TO_IDLE is unconditional.

Top module: `tw_cfg_port`

## Requirements
- R1: After reset every field output is 0, and so is the shift register.
- R2: A bit is shifted only on a rising bus_clk edge that occurs while bus_en is low. Falling edges are ignored. Rising edges while bus_en is high are ignored and leave the shift register unchanged.
- R3: Bits arrive most significant first, and the last bit is the address bit. When the address bit is 1, the long word D22..D0 is loaded from the 23 bits above it. The long word decodes as follows. ref_div_sel is D22..D21. swallow_cnt is D20..D16. main_div_sel is D15..D14. vco_band is D13. test_aux is D11. gauss_en is D10. comp_en is D9. gauss_dev is D8..D6. vco_trim is D5..D3. cp_trim is D2..D0. D12 drives nothing.
- R4: When the address bit is 0, the short word E10..E0 is loaded from the 11 bits just above it, and the long word is left unchanged. The short word decodes as follows. demod_trim is E10..E6. comp_gain is E5..E3. test_sel is E2..E0.
- R5: In a frame longer than 24 bits, only the last 24 bits count.
- R6: In a frame shorter than 24 bits, the new bits are appended below the bits the register already held, and the result is loaded as usual.
- R7: Field outputs change only in the cycle after a commit, never during shifting.
- R8: New field values appear after the fourth rising edge of clk, counting from the first edge at which bus_en is high. After the third such edge the old values still hold.
- R9: A frame-enable pulse with no bit-clock edges reloads the previous shift contents into the word chosen by the stored address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bit clock |
| bus_data | input | 1 | Serial data, MSB first |
| bus_en | input | 1 | Frame enable, active low |
| ref_div_sel | output | 2 | Reference divider code |
| swallow_cnt | output | 5 | Swallow counter value |
| main_div_sel | output | 2 | Main divider code |
| vco_band | output | 1 | Oscillator band select |
| test_aux | output | 1 | Auxiliary test bit |
| gauss_en | output | 1 | Transmit filter enable |
| comp_en | output | 1 | Modulation compensation enable |
| gauss_dev | output | 3 | Filter deviation code |
| vco_trim | output | 3 | Oscillator pretune code |
| cp_trim | output | 3 | Charge-pump current code |
| demod_trim | output | 5 | Demodulator centre trim |
| comp_gain | output | 3 | Compensation gain code |
| test_sel | output | 3 | Test mode selector |

## Verification
The bench aims at four cases.

- An overlong frame is sent. A design that kept the first 24 bits instead of the last would load garbage.
- A short frame is sent. A design that cleared the register at frame start, or counted bits, would lose the carried-over contents.
- A short-word load is made. A design that wrote the long word on every commit would corrupt the long word.
- Clock pulses are sent with the enable high, followed by an empty enable pulse. A design that shifted while idle would reload a changed word.

The bench checks the exact commit cycle, so an extra or missing pipeline register shows up as a one-cycle mismatch.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
    localparam int SR_W      = 24;
    localparam int LONG_W    = SR_W - 1;
    localparam int SHORT_W   = 11;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] sr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[WIDTH-2:0], din};
    end

    assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr));
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_hi,
    input  logic      bit_rise,
    output logic      shift_en,
    output logic      commit,
    output tw_state_e state
);
    tw_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!en_hi) nxt = ST_SHIFT;
            ST_SHIFT: if (en_hi)  nxt = ST_LOAD;
            ST_LOAD:              nxt = ST_IDLE;
            default:              nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SHIFT: shift_en = !en_hi && bit_rise;
            ST_LOAD:  commit   = 1'b1;
            default:  ;
        endcase
    end

    assert_load_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state == ST_IDLE));
    assert_shift_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && en_hi) |=> (state == ST_LOAD));
endmodule

// File: rtl/tw_cfg_port.sv
module tw_cfg_port
    import tw_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_clk,
    input  logic       bus_data,
    input  logic       bus_en,
    output logic [1:0] ref_div_sel,
    output logic [4:0] swallow_cnt,
    output logic [1:0] main_div_sel,
    output logic       vco_band,
    output logic       test_aux,
    output logic       gauss_en,
    output logic       comp_en,
    output logic [2:0] gauss_dev,
    output logic [2:0] vco_trim,
    output logic [2:0] cp_trim,
    output logic [4:0] demod_trim,
    output logic [2:0] comp_gain,
    output logic [2:0] test_sel
);
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_EN  = 2;

    logic [2:0]         sync_q;
    logic               bclk_prev;
    logic               bit_rise;
    logic               shift_en;
    logic               commit;
    tw_state_e          state;
    logic [SR_W-1:0]    sr;
    logic [LONG_W-1:0]  long_q;
    logic [SHORT_W-1:0] short_q;

    tw_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_en, bus_data, bus_clk}),
        .q(sync_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_prev <= 1'b0;
        else        bclk_prev <= sync_q[IDX_CLK];
    end
    assign bit_rise = sync_q[IDX_CLK] & ~bclk_prev;

    tw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .en_hi(sync_q[IDX_EN]), .bit_rise(bit_rise),
        .shift_en(shift_en), .commit(commit), .state(state)
    );

    tw_shift #(.WIDTH(SR_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_en(shift_en), .din(sync_q[IDX_DAT]), .sr(sr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            long_q  <= '0;
            short_q <= '0;
        end else if (commit) begin
            if (sr[0]) long_q  <= sr[SR_W-1:1];
            else       short_q <= sr[SHORT_W:1];
        end
    end

    assign ref_div_sel  = long_q[22:21];
    assign swallow_cnt  = long_q[20:16];
    assign main_div_sel = long_q[15:14];
    assign vco_band     = long_q[13];
    assign test_aux     = long_q[11];
    assign gauss_en     = long_q[10];
    assign comp_en      = long_q[9];
    assign gauss_dev    = long_q[8:6];
    assign vco_trim     = long_q[5:3];
    assign cp_trim      = long_q[2:0];
    assign demod_trim   = short_q[10:6];
    assign comp_gain    = short_q[5:3];
    assign test_sel     = short_q[2:0];

    assert_long_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sr[0]) |=> (long_q == $past(sr[SR_W-1:1])));
    assert_long_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !sr[0]) |=> $stable(long_q));
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(long_q) && $stable(short_q)));
    assert_idle_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(sr));
endmodule

// File: tb/tb_tw_cfg_port.sv
module tb_tw_cfg_port;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_clk = 1'b0, bus_data = 1'b0, bus_en = 1'b1;
    logic [1:0] ref_div_sel, main_div_sel;
    logic [4:0] swallow_cnt, demod_trim;
    logic vco_band, test_aux, gauss_en, comp_en;
    logic [2:0] gauss_dev, vco_trim, cp_trim, comp_gain, test_sel;

    always #5 clk = ~clk;

    tw_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data), .bus_en(bus_en),
        .ref_div_sel(ref_div_sel), .swallow_cnt(swallow_cnt), .main_div_sel(main_div_sel),
        .vco_band(vco_band), .test_aux(test_aux), .gauss_en(gauss_en), .comp_en(comp_en),
        .gauss_dev(gauss_dev), .vco_trim(vco_trim), .cp_trim(cp_trim),
        .demod_trim(demod_trim), .comp_gain(comp_gain), .test_sel(test_sel)
    );

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0, done = 1'b0;
    logic [23:0] m_sr = '0;
    logic [22:0] e_long = '0;
    logic [10:0] e_short = '0;

    function automatic logic [21:0] act_long();
        return {ref_div_sel, swallow_cnt, main_div_sel, vco_band, test_aux,
                gauss_en, comp_en, gauss_dev, vco_trim, cp_trim};
    endfunction
    function automatic logic [10:0] act_short();
        return {demod_trim, comp_gain, test_sel};
    endfunction

    // Every-clock comparison against the behavioural model (R7, R8 timing)
    always @(posedge clk) begin
        #2;
        if (cmp_on && !done) begin
            n_cmp++;
            if (act_long() !== {e_long[22:13], e_long[11:0]} || act_short() !== e_short) begin
                n_bad++;
                $display("FAIL %s t=%0t long act=%h exp=%h short act=%h exp=%h", cur_req, $time,
                         act_long(), {e_long[22:13], e_long[11:0]}, act_short(), e_short);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] v, input int n);
        bus_en = 1'b0;
        wait_n(8);
        for (int i = n - 1; i >= 0; i--) begin
            bus_data = v[i];
            wait_n(4);
            bus_clk = 1'b1;
            m_sr = {m_sr[22:0], v[i]};
            wait_n(4);
            bus_clk = 1'b0;
            wait_n(4);
        end
        wait_n(4);
        bus_en = 1'b1;
        wait_n(3);
        if (m_sr[0]) e_long = m_sr[23:1];
        else         e_short = m_sr[11:1];
        wait_n(30);
    endtask

    task automatic stray_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            bus_data = 1'b1;
            wait_n(4);
            bus_clk = 1'b1;
            wait_n(4);
            bus_clk = 1'b0;
            bus_data = 1'b0;
            wait_n(4);
        end
        wait_n(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        // R1 reset state
        n_cmp++;
        if (act_long() !== '0 || act_short() !== '0) begin
            n_bad++;
            $display("FAIL R1 long act=%h short act=%h exp=0", act_long(), act_short());
        end
        rst_n = 1'b1;
        cmp_on = 1'b1;
        wait_n(10);

        cur_req = "R3";
        send({40'd0, 23'h5A3C96, 1'b1}, 24);
        cur_req = "R3";
        send({40'd0, 23'h7FFFFF, 1'b1}, 24);

        cur_req = "R4";
        send({40'd0, 12'hABC, 11'h5B3, 1'b0}, 24);
        cur_req = "R4";
        send({52'd0, 11'h7FF, 1'b0}, 12);

        cur_req = "R5";
        send({34'd0, 6'h3F, 23'h12ABCD, 1'b1}, 30);

        cur_req = "R6";
        send({57'd0, 6'b101101, 1'b1}, 7);
        cur_req = "R6";
        send({59'd0, 4'b0110, 1'b0}, 5);

        cur_req = "R2";
        stray_pulses(10);
        cur_req = "R9";
        send(64'd0, 0);

        cur_req = "R2";
        send({40'd0, 23'h2C0555, 1'b1}, 24);
        stray_pulses(6);
        cur_req = "R9";
        send(64'd0, 0);

        cur_req = "R4";
        send({40'd0, 12'h000, 11'h000, 1'b0}, 24);
        cur_req = "R8";
        send({40'd0, 23'h000000, 1'b1}, 24);

        wait_n(20);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule